// File: doc/BRIEF.md
# Masked Packed Signed Multiply-High Unit

This block is a one-stage vector datapath. It splits two 512-bit source operands into 16-bit signed lanes and multiplies each pair of lanes into a 32-bit product. Each lane of the result receives the upper 16 bits of its product. A per-lane write mask, applied either by merging or by zeroing, decides which lanes take the new value. A mode select sets how many lanes are active. It also decides what happens to result bits above the active vector length: either they keep the previous destination value or they are forced to zero.

The caller presents both sources, the previous destination value, the mask and the controls together with `valid_i`. The finished 512-bit word appears on `result_o` one clock later, with `valid_o` high. The result register holds its value between operations. The unit raises no flags and no status of any kind.

Top module: `pmh_mulhi_unit`

## Requirements
- R1: Each active lane takes the two 16-bit lane values as two's-complement numbers, forms their full 32-bit signed product and writes product bits 31:16 to the lane. No saturation is applied.
- R2: Lane j occupies bits j*16+15 down to j*16, with lane 0 at the least significant end. The corner -32768 * -32768 gives 0x4000, and 0x7FFF * 0x7FFF gives 0x3FFF.
- R3: `mode_i` selects the active lane count:
  - code 0 is the legacy two-operand 128-bit mode with 8 lanes;
  - code 1 has 4 lanes (64 bits);
  - code 2 has 8 lanes (128 bits);
  - code 3 has 16 lanes (256 bits);
  - codes 4 to 7 have 32 lanes (512 bits).
- R4: In codes 1 to 7 with `mask_en_i` high, an active lane j receives its product only when `mask_i[j]` is 1. With `mask_en_i` low, every active lane receives its product.
- R5: When `zero_mode_i` is 0 (merge), an active lane that masking blocks takes its value from `dst_i`.
- R6: When `zero_mode_i` is 1 (zero), an active lane that masking blocks is set to all zeros.
- R7: In codes 1 to 7, every result bit above the active vector length is 0.
- R8: In code 0, result bits 511:128 equal `dst_i` bits 511:128. `mask_en_i` and `mask_i` have no effect in this mode, and all 8 lanes receive their products.
- R9: Mask bits at or above the active lane count have no effect on the result.
- R10: `valid_o` goes high exactly one clock after a cycle in which `valid_i` is high, and is low otherwise. `result_o` changes only after a cycle with `valid_i` high. Reset clears `valid_o` and `result_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| src_a_i | input | 512 | First packed source |
| src_b_i | input | 512 | Second packed source |
| dst_i | input | 512 | Previous destination value |
| mask_i | input | 32 | Per-lane write mask |
| mode_i | input | 3 | Vector length and mode select |
| mask_en_i | input | 1 | Enables per-lane masking |
| zero_mode_i | input | 1 | 1 = zero blocked lanes, 0 = merge |
| valid_o | output | 1 | Result valid, one clock after valid_i |
| result_o | output | 512 | Registered packed result |

## Verification
The bench targets the signed extremes 0x8000, 0x7FFF and 0xFFFF. An unsigned or truncated multiplier would return wrong high halves for these values, and a saturating one would return 0x7FFF instead of 0x4000. It sweeps every mode code with random masks, including mask bits set above the active lane count. A wrong length decode or a failure to ignore those bits would leave stray lanes written or cleared. Legacy mode is checked against random upper destination bits and random masks: clearing the upper bits or honouring the mask there shows up as a mismatch. Idle cycles with changed inputs expose a result register that is not gated by the valid strobe.

// File: rtl/pmh_pkg.sv
package pmh_pkg;
  localparam int unsigned LANE_W = 16;

  typedef enum logic [2:0] {
    MODE_LEG128 = 3'd0,
    MODE_V64    = 3'd1,
    MODE_V128   = 3'd2,
    MODE_V256   = 3'd3,
    MODE_V512   = 3'd4
  } mode_e;
endpackage

// File: rtl/pmh_lane.sv
module pmh_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] hi_o
);
  localparam int unsigned PW = 2 * W;
  logic signed [PW-1:0] prod;

  always_comb begin
    prod = PW'($signed(a_i)) * PW'($signed(b_i));
    hi_o = prod[PW-1:W];
  end
endmodule

// File: rtl/pmh_ctrl.sv
module pmh_ctrl #(
  parameter int unsigned NL = 32
) (
  input  logic [2:0]    mode_i,
  input  logic [NL-1:0] mask_i,
  input  logic          mask_en_i,
  output logic [NL-1:0] lane_act_o,
  output logic [NL-1:0] lane_wr_o,
  output logic          keep_upper_o
);
  localparam int unsigned CNT_W = $clog2(NL + 1);

  logic [CNT_W-1:0] act_cnt;
  logic             legacy;

  always_comb begin
    legacy = 1'b0;
    unique case (mode_i)
      3'd0:    begin act_cnt = CNT_W'(8); legacy = 1'b1; end
      3'd1:    act_cnt = CNT_W'(4);
      3'd2:    act_cnt = CNT_W'(8);
      3'd3:    act_cnt = CNT_W'(16);
      default: act_cnt = CNT_W'(NL);
    endcase
  end

  assign keep_upper_o = legacy;

  for (genvar j = 0; j < NL; j++) begin : g_lane
    assign lane_act_o[j] = CNT_W'(j) < act_cnt;
    // legacy mode has no masking
    assign lane_wr_o[j]  = lane_act_o[j] & (legacy | ~mask_en_i | mask_i[j]);
  end
endmodule

// File: rtl/pmh_mulhi_unit.sv
module pmh_mulhi_unit #(
  parameter int unsigned DATA_W = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W/pmh_pkg::LANE_W-1:0] mask_i,
  input  logic [2:0]        mode_i,
  input  logic              mask_en_i,
  input  logic              zero_mode_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned LW = pmh_pkg::LANE_W;
  localparam int unsigned NL = DATA_W / LW;

  logic [NL-1:0]     lane_act, lane_wr;
  logic              keep_upper;
  logic [DATA_W-1:0] nxt;

  pmh_ctrl #(.NL(NL)) u_ctrl (
    .mode_i       (mode_i),
    .mask_i       (mask_i),
    .mask_en_i    (mask_en_i),
    .lane_act_o   (lane_act),
    .lane_wr_o    (lane_wr),
    .keep_upper_o (keep_upper)
  );

  for (genvar j = 0; j < NL; j++) begin : g_lane
    logic [LW-1:0] hi, old;
    assign old = dst_i[j*LW +: LW];

    pmh_lane #(.W(LW)) u_lane (
      .a_i  (src_a_i[j*LW +: LW]),
      .b_i  (src_b_i[j*LW +: LW]),
      .hi_o (hi)
    );

    always_comb begin
      if (lane_wr[j])        nxt[j*LW +: LW] = hi;
      else if (lane_act[j])  nxt[j*LW +: LW] = zero_mode_i ? '0 : old;
      else                   nxt[j*LW +: LW] = keep_upper ? old : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt;
    end
  end
endmodule

// File: rtl/pmh_mulhi_chk.sv
module pmh_mulhi_chk #(
  parameter int unsigned DATA_W = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W/pmh_pkg::LANE_W-1:0] mask_i,
  input logic [2:0]        mode_i,
  input logic              mask_en_i,
  input logic              zero_mode_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r10_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r7_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 3'd1) |=> result_o[DATA_W-1:64] == '0);
  a_r8_legacy_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 3'd0) |=> result_o[DATA_W-1:128] == $past(dst_i[DATA_W-1:128]));
  a_r5_merge_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i >= 3'd4 && mask_en_i && !zero_mode_i && mask_i == '0)
      |=> result_o == $past(dst_i));
  a_r6_zero_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i != 3'd0 && mask_en_i && zero_mode_i && mask_i == '0)
      |=> result_o == '0);
endmodule

bind pmh_mulhi_unit pmh_mulhi_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_pmh_mulhi_unit.sv
`timescale 1ns/1ps
module tb_pmh_mulhi_unit;
  localparam int DW = 512;
  localparam int NL = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic [NL-1:0] mask_i = '0;
  logic [2:0]    mode_i = '0;
  logic          mask_en_i = 1'b0, zero_mode_i = 1'b0;
  logic          valid_o;
  logic [DW-1:0] result_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pmh_mulhi_unit #(.DATA_W(DW)) dut (.*);

  function automatic logic [15:0] hi16(input logic [15:0] a, input logic [15:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return 16'(p >>> 16);
  endfunction

  function automatic logic [DW-1:0] model(input logic [DW-1:0] a, b, d,
      input logic [NL-1:0] m, input logic [2:0] md, input logic men, zm);
    logic [DW-1:0] r;
    int lanes;
    bit leg;
    leg = (md == 3'd0);
    lanes = (md == 3'd1) ? 4 : (md == 3'd0 || md == 3'd2) ? 8 : (md == 3'd3) ? 16 : 32;
    for (int j = 0; j < NL; j++) begin
      if (j < lanes) begin
        if (leg || !men || m[j]) r[j*16 +: 16] = hi16(a[j*16 +: 16], b[j*16 +: 16]);
        else r[j*16 +: 16] = zm ? 16'h0 : d[j*16 +: 16];
      end else r[j*16 +: 16] = leg ? d[j*16 +: 16] : 16'h0;
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] rvec();
    logic [DW-1:0] v;
    for (int j = 0; j < NL; j++) begin
      case ($urandom % 8)
        0: v[j*16 +: 16] = 16'h8000;
        1: v[j*16 +: 16] = 16'h7FFF;
        2: v[j*16 +: 16] = 16'hFFFF;
        default: v[j*16 +: 16] = 16'($urandom);
      endcase
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [DW-1:0] a, b, d,
      input logic [NL-1:0] m, input logic [2:0] md, input logic men, zm);
    @(negedge clk_i);
    src_a_i = a; src_b_i = b; dst_i = d; mask_i = m;
    mode_i = md; mask_en_i = men; zero_mode_i = zm; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " R10 valid"}, DW'(valid_o), DW'(1'b1));
    check(req, result_o, model(a, b, d, m, md, men, zm));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] last;
    void'($urandom(32'd20240611));
    #9;
    check("R10 reset valid", DW'(valid_o), DW'(1'b0));
    check("R10 reset result", result_o, '0);
    rst_ni = 1'b1;

    // R2 corners: -32768^2 -> 0x4000, 0x7FFF^2 -> 0x3FFF, lane placement
    apply("R2 corner min*min", {NL{16'h8000}}, {NL{16'h8000}}, '0, '0, 3'd4, 1'b0, 1'b0);
    check("R2 lane value", DW'(result_o[31*16 +: 16]), DW'(16'h4000));
    apply("R2 corner max*max", {NL{16'h7FFF}}, {NL{16'h7FFF}}, '0, '0, 3'd4, 1'b0, 1'b0);
    check("R2 lane value", DW'(result_o[15:0]), DW'(16'h3FFF));
    apply("R1 min*max", {NL{16'h8000}}, {NL{16'h7FFF}}, '0, '0, 3'd4, 1'b0, 1'b0);
    check("R1 lane value", DW'(result_o[15:0]), DW'(16'hC000));
    apply("R1 -1*-1", {NL{16'hFFFF}}, {NL{16'hFFFF}}, '0, '0, 3'd4, 1'b0, 1'b0);
    check("R1 lane value", DW'(result_o[15:0]), DW'(16'h0000));
    apply("R2 lane order", {{(NL-1){16'h0}}, 16'h4000}, {{(NL-1){16'h0}}, 16'h0008}, '0, '0, 3'd4, 1'b0, 1'b0);
    check("R2 lane0 only", result_o, DW'(32'h0002));

    // R5/R6 mask all zero
    apply("R5 merge none", rvec(), rvec(), rvec(), '0, 3'd4, 1'b1, 1'b0);
    apply("R6 zero none", rvec(), rvec(), rvec(), '0, 3'd3, 1'b1, 1'b1);
    // R8 legacy ignores mask, preserves upper
    apply("R8 legacy masked", rvec(), rvec(), rvec(), 32'h0, 3'd0, 1'b1, 1'b1);
    // R9 upper mask bits ignored in 64-bit mode
    apply("R9 mask above", rvec(), rvec(), rvec(), 32'hFFFF_FFF5, 3'd1, 1'b1, 1'b1);
    check("R7 R9 upper zero", DW'(result_o[DW-1:64]), '0);

    // R3 R4 R5 R6 R7 random sweep across all mode codes
    for (int i = 0; i < 400; i++) begin
      apply("R3 R4 R5 R6 R7 R8 sweep", rvec(), rvec(), rvec(), NL'($urandom),
            3'(i % 8), 1'(i / 8), 1'(i / 16));
    end

    // R10 hold: no valid, changed inputs
    last = result_o;
    @(negedge clk_i);
    src_a_i = rvec(); src_b_i = rvec(); dst_i = rvec(); mode_i = 3'd4;
    @(negedge clk_i);
    check("R10 hold valid", DW'(valid_o), DW'(1'b0));
    check("R10 hold result", result_o, last);

    done = 1'b1;
    finish_run();
  end
endmodule